// File: doc/BRIEF.md
# PHY Control Sequencer (MAC side, single lane)

This block sits between link-management logic and a PIPE-style PHY on one lane. Upper logic raises one-cycle requests for three operations: receiver detection, a power-state change or a link-rate change. The sequencer checks each request and drives the matching PHY control output. It then waits for the PHY's single-cycle status pulse and reports completion with a one-cycle `done` strobe. For a receiver detection, `done` also carries the detect result.

Only one operation is in flight at a time. `busy` marks the open window. Illegal requests are refused with a one-cycle `reqError` pulse, and a programmable limit ends a window that the PHY never closes with a `timeoutErr` pulse. While a rate change is pending, the received valid, data and status are masked on their way to upper logic. The electrical-idle, compliance-disparity and receive-polarity controls are plain levels that are registered from their request inputs.

Top module: `phyCtrlSeq`

## Requirements
- R1: After reset, phyPowerDown is 10 (P1), phyRate is 00, and phyDetect, busy, done, detectFound, reqError, timeoutErr, phyElecIdle, phyCompliance and phyPolarity are all 0.
- R2: A detect request is accepted only while phyPowerDown is 10. When it is accepted, phyDetect and busy are 1 on the next cycle. In any other power state the request changes no control output and raises reqError for exactly one cycle on the next cycle.
- R3: A power request with code 00, 01 or 10 drives phyPowerDown to that code on the next cycle and sets busy. Code 11 is refused with a one-cycle reqError and leaves phyPowerDown unchanged, so phyPowerDown is never 11.
- R4: A rate request with code 00, 01 or 10 drives phyRate to that code on the next cycle and sets busy. Code 11 is refused with a one-cycle reqError and leaves phyRate unchanged.
- R5: When phyStatus is 1 while busy, on the next cycle busy and phyDetect are 0 and done is 1 for exactly one cycle.
- R6: detectFound is 1 together with done only when the finished operation was a detection and phyRxStatus was 001 in the phyStatus cycle. Otherwise detectFound is 0, including for status 000.
- R7: From the cycle phyRate takes a requested value through the cycle phyStatus pulses, rxValidOut is 0 and rxDataOut and rxStatusOut are all zeros. At all other times the three follow phyRxValid, phyRxData and phyRxStatus in the same cycle.
- R8: phyElecIdle, phyCompliance and phyPolarity equal idleReq, complianceReq and polarityReq one cycle later, whatever else is happening.
- R9: Requests made while busy are dropped and have no later effect. phyStatus while not busy is ignored.
- R10: When several requests arrive together while not busy, detect has priority over power, and power has priority over rate. Only the winner is acted on.
- R11: If phyStatus does not pulse, busy stays high for max(timeoutLimit,1) cycles. Then busy, phyDetect and the rx mask drop, timeoutErr is 1 for one cycle and done stays 0. Control outputs keep their requested values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PHY parallel clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqDetect | input | 1 | One-cycle request for receiver detection |
| reqPower | input | 1 | One-cycle request for a power-state change |
| reqPowerState | input | 2 | Target power code (00 P0, 01 P0s, 10 P1, 11 refused) |
| reqRate | input | 1 | One-cycle request for a rate change |
| reqRateSel | input | 2 | Target rate code (00, 01, 10; 11 refused) |
| idleReq | input | 1 | Electrical-idle level request |
| complianceReq | input | 1 | Negative-disparity level request |
| polarityReq | input | 1 | Receive-inversion level request |
| timeoutLimit | input | TMO_W | Maximum busy cycles before timeout |
| phyStatus | input | 1 | PHY single-cycle completion pulse |
| phyRxValid | input | 1 | Receive valid from the PHY |
| phyRxData | input | DATA_W | Receive data from the PHY |
| phyRxStatus | input | 3 | Receive status from the PHY |
| phyDetect | output | 1 | Receiver-detect control to the PHY |
| phyPowerDown | output | 2 | Power-state control to the PHY |
| phyRate | output | 2 | Rate control to the PHY |
| phyElecIdle | output | 1 | Transmit electrical-idle control |
| phyCompliance | output | 1 | Force negative running disparity |
| phyPolarity | output | 1 | Invert received data |
| busy | output | 1 | An operation is in flight |
| done | output | 1 | One-cycle completion strobe |
| detectFound | output | 1 | Receiver present, valid with done |
| reqError | output | 1 | One-cycle request-refused pulse |
| timeoutErr | output | 1 | One-cycle timeout pulse |
| rxValidOut | output | 1 | Masked receive valid |
| rxDataOut | output | DATA_W | Masked receive data |
| rxStatusOut | output | 3 | Masked receive status |

## Verification
The hardest behaviour to reach from the ports is timeout expiry. It needs a PHY that never answers. The bench lowers timeoutLimit to a few cycles, withholds phyStatus and counts the busy cycles. The next hardest case is a collision: a request that arrives while a window is open, or a status pulse that arrives while none is open. The bench keeps a rate window open, fires a power request and stray pulses into it, and then confirms that phyPowerDown never moved. A behavioural model checks every output on every cycle, so the masking edges of R7 are compared in the exact cycles where they start and end.

// File: rtl/phySeqPkg.sv
package phySeqPkg;

  localparam logic [1:0] PD_P0  = 2'b00;
  localparam logic [1:0] PD_P0S = 2'b01;
  localparam logic [1:0] PD_P1  = 2'b10;
  localparam logic [1:0] PD_P2  = 2'b11;
  localparam logic [1:0] RATE_BAD = 2'b11;
  localparam logic [2:0] RXST_FOUND = 3'b001;

  typedef enum logic {
    ST_IDLE,
    ST_WAIT
  } seqState_e;

  typedef enum logic [1:0] {
    OP_NONE,
    OP_DETECT,
    OP_POWER,
    OP_RATE
  } opKind_e;

  // strobes from control to datapath, each high for one cycle
  typedef struct packed {
    logic startDetect;
    logic startPower;
    logic startRate;
    logic reject;
    logic finish;
    logic finishDetect;
    logic expire;
  } ctrlStrb_t;

endpackage

// File: rtl/phySeqCtrl.sv
module phySeqCtrl
  import phySeqPkg::*;
#(
  parameter int TMO_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqDetect,
  input  logic             reqPower,
  input  logic [1:0]       reqPowerState,
  input  logic             reqRate,
  input  logic [1:0]       reqRateSel,
  input  logic [TMO_W-1:0] timeoutLimit,
  input  logic             phyStatus,
  input  logic [1:0]       curPowerDown,
  output ctrlStrb_t        strb,
  output logic             busy
);

  localparam int CNT_W = TMO_W + 1;

  seqState_e       state;
  opKind_e         curOp;
  logic [CNT_W-1:0] waitCnt;
  logic [CNT_W-1:0] waitNext;
  logic            limitHit;

  assign waitNext = waitCnt + CNT_W'(1);
  // a limit of zero behaves as one because waitNext is never below one
  assign limitHit = (waitNext >= {1'b0, timeoutLimit});

  always_comb begin
    strb = '0;
    if (state == ST_IDLE) begin
      if (reqDetect) begin
        if (curPowerDown == PD_P1) strb.startDetect = 1'b1;
        else                       strb.reject      = 1'b1;
      end else if (reqPower) begin
        if (reqPowerState == PD_P2) strb.reject     = 1'b1;
        else                        strb.startPower = 1'b1;
      end else if (reqRate) begin
        if (reqRateSel == RATE_BAD) strb.reject    = 1'b1;
        else                        strb.startRate = 1'b1;
      end
    end else begin
      if (phyStatus) begin
        strb.finish       = 1'b1;
        strb.finishDetect = (curOp == OP_DETECT);
      end else if (limitHit) begin
        strb.expire = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      curOp   <= OP_NONE;
      waitCnt <= '0;
    end else begin
      if (strb.startDetect || strb.startPower || strb.startRate) begin
        state   <= ST_WAIT;
        waitCnt <= '0;
        if (strb.startDetect)     curOp <= OP_DETECT;
        else if (strb.startPower) curOp <= OP_POWER;
        else                      curOp <= OP_RATE;
      end else if (strb.finish || strb.expire) begin
        state   <= ST_IDLE;
        curOp   <= OP_NONE;
        waitCnt <= '0;
      end else if (state == ST_WAIT) begin
        waitCnt <= waitNext;
      end
    end
  end

  assign busy = (state == ST_WAIT);

endmodule

// File: rtl/phySeqDp.sv
module phySeqDp
  import phySeqPkg::*;
#(
  parameter int         DATA_W   = 32,
  parameter logic [1:0] RESET_PD = 2'b10
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [1:0]        reqPowerState,
  input  logic [1:0]        reqRateSel,
  input  logic              idleReq,
  input  logic              complianceReq,
  input  logic              polarityReq,
  input  logic              phyRxValid,
  input  logic [DATA_W-1:0] phyRxData,
  input  logic [2:0]        phyRxStatus,
  output logic              phyDetect,
  output logic [1:0]        phyPowerDown,
  output logic [1:0]        phyRate,
  output logic              phyElecIdle,
  output logic              phyCompliance,
  output logic              phyPolarity,
  output logic              done,
  output logic              detectFound,
  output logic              reqError,
  output logic              timeoutErr,
  output logic              rxValidOut,
  output logic [DATA_W-1:0] rxDataOut,
  output logic [2:0]        rxStatusOut
);

  logic rateGate;
  logic closeWin;

  assign closeWin = strb.finish | strb.expire;

  // control outputs that stay until changed
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phyDetect    <= 1'b0;
      phyPowerDown <= RESET_PD;
      phyRate      <= 2'b00;
      rateGate     <= 1'b0;
    end else begin
      if (strb.startDetect)  phyDetect <= 1'b1;
      else if (closeWin)     phyDetect <= 1'b0;
      if (strb.startPower)   phyPowerDown <= reqPowerState;
      if (strb.startRate)    phyRate <= reqRateSel;
      if (strb.startRate)    rateGate <= 1'b1;
      else if (closeWin)     rateGate <= 1'b0;
    end
  end

  // one-cycle reporting pulses
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      done        <= 1'b0;
      detectFound <= 1'b0;
      reqError    <= 1'b0;
      timeoutErr  <= 1'b0;
    end else begin
      done        <= strb.finish;
      detectFound <= strb.finish & strb.finishDetect & (phyRxStatus == RXST_FOUND);
      reqError    <= strb.reject;
      timeoutErr  <= strb.expire;
    end
  end

  // level controls, one register stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phyElecIdle   <= 1'b0;
      phyCompliance <= 1'b0;
      phyPolarity   <= 1'b0;
    end else begin
      phyElecIdle   <= idleReq;
      phyCompliance <= complianceReq;
      phyPolarity   <= polarityReq;
    end
  end

  // receive path masking during a rate change
  assign rxValidOut  = phyRxValid & ~rateGate;
  assign rxDataOut   = rateGate ? '0 : phyRxData;
  assign rxStatusOut = rateGate ? 3'b000 : phyRxStatus;

endmodule

// File: rtl/phyCtrlSeq.sv
module phyCtrlSeq
  import phySeqPkg::*;
#(
  parameter int         DATA_W   = 32,
  parameter int         TMO_W    = 24,
  parameter logic [1:0] RESET_PD = 2'b10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqDetect,
  input  logic              reqPower,
  input  logic [1:0]        reqPowerState,
  input  logic              reqRate,
  input  logic [1:0]        reqRateSel,
  input  logic              idleReq,
  input  logic              complianceReq,
  input  logic              polarityReq,
  input  logic [TMO_W-1:0]  timeoutLimit,
  input  logic              phyStatus,
  input  logic              phyRxValid,
  input  logic [DATA_W-1:0] phyRxData,
  input  logic [2:0]        phyRxStatus,
  output logic              phyDetect,
  output logic [1:0]        phyPowerDown,
  output logic [1:0]        phyRate,
  output logic              phyElecIdle,
  output logic              phyCompliance,
  output logic              phyPolarity,
  output logic              busy,
  output logic              done,
  output logic              detectFound,
  output logic              reqError,
  output logic              timeoutErr,
  output logic              rxValidOut,
  output logic [DATA_W-1:0] rxDataOut,
  output logic [2:0]        rxStatusOut
);

  ctrlStrb_t strb;

  phySeqCtrl #(.TMO_W(TMO_W)) uCtrl (
    .clk           (clk),
    .rstN          (rstN),
    .reqDetect     (reqDetect),
    .reqPower      (reqPower),
    .reqPowerState (reqPowerState),
    .reqRate       (reqRate),
    .reqRateSel    (reqRateSel),
    .timeoutLimit  (timeoutLimit),
    .phyStatus     (phyStatus),
    .curPowerDown  (phyPowerDown),
    .strb          (strb),
    .busy          (busy)
  );

  phySeqDp #(.DATA_W(DATA_W), .RESET_PD(RESET_PD)) uDp (
    .clk           (clk),
    .rstN          (rstN),
    .strb          (strb),
    .reqPowerState (reqPowerState),
    .reqRateSel    (reqRateSel),
    .idleReq       (idleReq),
    .complianceReq (complianceReq),
    .polarityReq   (polarityReq),
    .phyRxValid    (phyRxValid),
    .phyRxData     (phyRxData),
    .phyRxStatus   (phyRxStatus),
    .phyDetect     (phyDetect),
    .phyPowerDown  (phyPowerDown),
    .phyRate       (phyRate),
    .phyElecIdle   (phyElecIdle),
    .phyCompliance (phyCompliance),
    .phyPolarity   (phyPolarity),
    .done          (done),
    .detectFound   (detectFound),
    .reqError      (reqError),
    .timeoutErr    (timeoutErr),
    .rxValidOut    (rxValidOut),
    .rxDataOut     (rxDataOut),
    .rxStatusOut   (rxStatusOut)
  );

endmodule

// File: rtl/phySeqChk.sv
module phySeqChk (
  input logic       clk,
  input logic       rstN,
  input logic       phyStatus,
  input logic       busy,
  input logic       done,
  input logic       reqError,
  input logic       timeoutErr,
  input logic       detectFound,
  input logic       phyDetect,
  input logic [1:0] phyPowerDown,
  input logic [1:0] phyRate,
  input logic       rxValidOut
);

  logic [1:0] prevRate;
  logic       rateOpQ;
  logic       gateExp;

  // a rate window opens in the cycle phyRate moves and lasts while busy
  assign gateExp = busy & ((phyRate != prevRate) | rateOpQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevRate <= 2'b00;
      rateOpQ  <= 1'b0;
    end else begin
      prevRate <= phyRate;
      rateOpQ  <= gateExp;
    end
  end

  p_detect_only_p1_r2: assert property (@(posedge clk) disable iff (!rstN)
    phyDetect |-> (phyPowerDown == 2'b10));

  p_never_p2_r3: assert property (@(posedge clk) disable iff (!rstN)
    phyPowerDown != 2'b11);

  p_rate_legal_r4: assert property (@(posedge clk) disable iff (!rstN)
    phyRate != 2'b11);

  p_status_closes_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && phyStatus) |=> (done && !busy && !phyDetect));

  p_done_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_found_with_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    detectFound |-> done);

  p_rx_masked_r7: assert property (@(posedge clk) disable iff (!rstN)
    gateExp |-> !rxValidOut);

  p_idle_status_ignored_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && phyStatus) |=> !done);

  p_refuse_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqError |-> !busy);

  p_timeout_clean_r11: assert property (@(posedge clk) disable iff (!rstN)
    timeoutErr |-> (!busy && !done && !phyDetect));

endmodule

bind phyCtrlSeq phySeqChk uChk (
  .clk          (clk),
  .rstN         (rstN),
  .phyStatus    (phyStatus),
  .busy         (busy),
  .done         (done),
  .reqError     (reqError),
  .timeoutErr   (timeoutErr),
  .detectFound  (detectFound),
  .phyDetect    (phyDetect),
  .phyPowerDown (phyPowerDown),
  .phyRate      (phyRate),
  .rxValidOut   (rxValidOut)
);

// File: tb/phyCtrlSeq_test.sv
`timescale 1ns/1ps
module phyCtrlSeq_test;

  localparam int DATA_W = 32;
  localparam int TMO_W  = 24;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqDetect = 0, reqPower = 0, reqRate = 0;
  logic [1:0]        reqPowerState = 0, reqRateSel = 0;
  logic              idleReq = 0, complianceReq = 0, polarityReq = 0;
  logic [TMO_W-1:0]  timeoutLimit = 24'd2000;
  logic              phyStatus = 0, phyRxValid = 0;
  logic [DATA_W-1:0] phyRxData = 0;
  logic [2:0]        phyRxStatus = 0;
  logic              phyDetect, phyElecIdle, phyCompliance, phyPolarity;
  logic [1:0]        phyPowerDown, phyRate;
  logic              busy, done, detectFound, reqError, timeoutErr, rxValidOut;
  logic [DATA_W-1:0] rxDataOut;
  logic [2:0]        rxStatusOut;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  phyCtrlSeq #(.DATA_W(DATA_W), .TMO_W(TMO_W)) uut (.*);

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit     mBusy, mDet, mGate, mOpDet, mDone, mFound, mErr, mTmo, mIdle, mComp, mPol;
  int     mPd, mRate, mCnt;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mBusy = 0; mDet = 0; mGate = 0; mOpDet = 0; mDone = 0; mFound = 0;
      mErr = 0; mTmo = 0; mIdle = 0; mComp = 0; mPol = 0;
      mPd = 2; mRate = 0; mCnt = 0;
    end else begin
      mDone = 0; mFound = 0; mErr = 0; mTmo = 0;
      if (!mBusy) begin
        if (reqDetect) begin
          if (mPd == 2) begin mDet = 1; mBusy = 1; mOpDet = 1; mCnt = 0; end
          else mErr = 1;
        end else if (reqPower) begin
          if (reqPowerState == 3) mErr = 1;
          else begin mPd = reqPowerState; mBusy = 1; mOpDet = 0; mCnt = 0; end
        end else if (reqRate) begin
          if (reqRateSel == 3) mErr = 1;
          else begin mRate = reqRateSel; mBusy = 1; mGate = 1; mOpDet = 0; mCnt = 0; end
        end
      end else if (phyStatus) begin
        mDone = 1; mFound = mOpDet && (phyRxStatus == 3'b001);
        mBusy = 0; mDet = 0; mGate = 0;
      end else if (mCnt + 1 >= int'(timeoutLimit)) begin
        mTmo = 1; mBusy = 0; mDet = 0; mGate = 0;
      end else begin
        mCnt++;
      end
      mIdle = idleReq; mComp = complianceReq; mPol = polarityReq;
    end
  end

  // compare every cycle, away from the edges
  always @(posedge clk) begin
    #2;
    if (rstN && !finished) begin
      chk("R1/R5 busy", busy, mBusy);
      chk("R2 phyDetect", phyDetect, mDet);
      chk("R3 phyPowerDown", phyPowerDown, mPd);
      chk("R4 phyRate", phyRate, mRate);
      chk("R5 done", done, mDone);
      chk("R6 detectFound", detectFound, mFound);
      chk("R2 reqError", reqError, mErr);
      chk("R11 timeoutErr", timeoutErr, mTmo);
      chk("R8 levels", {phyElecIdle, phyCompliance, phyPolarity}, {mIdle, mComp, mPol});
      chk("R7 rxValidOut", rxValidOut, phyRxValid & !mGate);
      chk("R7 rxDataOut", rxDataOut, mGate ? 0 : phyRxData);
      chk("R7 rxStatusOut", rxStatusOut, mGate ? 0 : phyRxStatus);
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // kind: 0 detect, 1 power, 2 rate
  task automatic pulseReq(input int kind, input logic [1:0] val);
    @(negedge clk);
    reqDetect = (kind == 0);
    reqPower  = (kind == 1);
    reqRate   = (kind == 2);
    reqPowerState = val;
    reqRateSel    = val;
    @(negedge clk);
    reqDetect = 0; reqPower = 0; reqRate = 0;
  endtask

  task automatic pulseStatus(input logic [2:0] st);
    @(negedge clk);
    phyStatus = 1; phyRxStatus = st;
    @(negedge clk);
    phyStatus = 0; phyRxStatus = 3'b000;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rstN = 1;
    #1;
    chk("R1 reset pd", phyPowerDown, 2);
    chk("R1 reset rate", phyRate, 0);
    chk("R1 reset busy", {busy, done, phyDetect, reqError, timeoutErr}, 0);

    // R8 level controls
    @(negedge clk); idleReq = 1; complianceReq = 1;
    @(negedge clk); #1;
    chk("R8 idle/compliance", {phyElecIdle, phyCompliance, phyPolarity}, 3'b110);
    polarityReq = 1; idleReq = 0;
    @(negedge clk); #1;
    chk("R8 polarity", {phyElecIdle, phyCompliance, phyPolarity}, 3'b011);
    complianceReq = 0; polarityReq = 0;

    // R2/R6 detect in P1, receiver present
    pulseReq(0, 0); #1;
    chk("R2 detect accepted", {phyDetect, busy}, 3);
    cyc(4);
    pulseStatus(3'b001); #1;
    chk("R5 done after status", {done, busy, phyDetect}, 3'b100);
    chk("R6 found", detectFound, 1);
    @(negedge clk); #1;
    chk("R5 done one cycle", done, 0);

    // R6 detect with no receiver
    pulseReq(0, 0);
    cyc(2);
    pulseStatus(3'b000); #1;
    chk("R6 not found", {done, detectFound}, 2'b10);

    // R9 stray status while idle
    pulseStatus(3'b001); #1;
    chk("R9 idle status ignored", done, 0);

    // R3 power to P0, then R2 detect refused outside P1
    pulseReq(1, 2'b00); #1;
    chk("R3 pd to P0", {phyPowerDown, busy}, 3'b001);
    pulseStatus(0);
    pulseReq(0, 0); #1;
    chk("R2 detect refused", {reqError, phyDetect, busy}, 3'b100);
    @(negedge clk); #1;
    chk("R2 error one cycle", reqError, 0);

    // R3 P2 refused
    pulseReq(1, 2'b11); #1;
    chk("R3 P2 refused", {reqError, busy}, 2'b10);
    chk("R3 pd unchanged", phyPowerDown, 0);

    // back to P1, then R10 priority
    pulseReq(1, 2'b10);
    pulseStatus(0);
    @(negedge clk);
    reqDetect = 1; reqPower = 1; reqPowerState = 2'b01; reqRate = 1; reqRateSel = 2'b01;
    @(negedge clk);
    reqDetect = 0; reqPower = 0; reqRate = 0; #1;
    chk("R10 detect wins", {phyDetect, phyPowerDown, phyRate}, 5'b1_10_00);
    pulseStatus(0);

    // R4/R7 rate change with masking
    @(negedge clk); phyRxValid = 1; phyRxData = 32'hA5A5_0F0F; phyRxStatus = 3'b100; #1;
    chk("R7 pass through", {rxValidOut, rxStatusOut}, 4'b1100);
    pulseReq(2, 2'b10); #1;
    chk("R4 rate Gen3", {phyRate, busy}, 3'b101);
    chk("R7 valid masked", rxValidOut, 0);
    chk("R7 data masked", rxDataOut, 0);
    // R9 request while busy is dropped
    pulseReq(1, 2'b01);
    cyc(5);
    @(negedge clk); phyStatus = 1; #1;
    chk("R7 masked in status cycle", rxValidOut, 0);
    @(negedge clk); phyStatus = 0; #1;
    chk("R7 mask lifted", {rxValidOut, done}, 2'b11);
    chk("R9 busy request dropped", phyPowerDown, 2);
    cyc(2); #1;
    chk("R9 no late effect", {phyPowerDown, busy}, 3'b100);
    phyRxValid = 0; phyRxData = 0; phyRxStatus = 0;

    // R4 invalid rate
    pulseReq(2, 2'b11); #1;
    chk("R4 rate 11 refused", {reqError, busy, phyRate}, 4'b1010);

    // R11 timeout
    timeoutLimit = 24'd8;
    pulseReq(1, 2'b01);
    begin
      int n = 0;
      while (busy && n < 100) begin n++; @(negedge clk); end
      #1;
      chk("R11 busy length", n, 8);
      chk("R11 timeout pulse", {timeoutErr, done, busy}, 3'b100);
      chk("R11 pd kept", phyPowerDown, 1);
    end

    // R11 rate timeout releases mask
    timeoutLimit = 24'd3;
    pulseReq(2, 2'b01);
    phyRxValid = 1;
    cyc(3); #1;
    chk("R11 mask lifted on timeout", {rxValidOut, timeoutErr}, 2'b11);
    phyRxValid = 0;
    cyc(3);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule